// File: doc/BRIEF.md
# Fixed-Priority Interrupt Controller with Spurious Vector Return

This block gathers eight request lines and offers the most urgent one to a processor. Each line passes through a two-stage synchronizer and then into a request latch. The latch tracks the line levels while no acknowledge is in progress. A mask register removes levels from arbitration. An in-service register records the levels the processor is handling, so that equal and less urgent lines are held off until software sends an end-of-interrupt command. Level 0 is the most urgent and level 7 the least. The priority order never changes.

The processor answers the interrupt output with two acknowledge pulses. The first pulse freezes the request latch and picks the winning level. It also marks that level in service and drops the interrupt output. The second pulse presents an 8-bit vector, built from a 5-bit base and the 3-bit level, for one cycle. A request can disappear or be masked after the interrupt output has been raised. If no eligible request remains when the first pulse arrives, the block returns the level-7 vector as a spurious answer and leaves the in-service register untouched.

Top module: `prio_irq_ctrl`

## Requirements
- R1: When several eligible requests are pending, the lowest-numbered level wins. The returned vector is `{base[4:0], level[2:0]}`, with the base in bits 7..3 and the level in bits 2..0.
- R2: While an in-service bit k is set, requests at level k or higher-numbered levels do not raise `int_out`. A request at a level below k raises it without any end-of-interrupt command.
- R3: A pulse on `eoi_stb` clears only the lowest-numbered in-service bit that is set.
- R4: The request latch copies the synchronized inputs every cycle until the first acknowledge pulse. It then holds its value until the second pulse. A request that appears between the two pulses is first seen in the cycle after the second pulse.
- R5: Once `int_out` is high, it stays high until the first acknowledge pulse. This holds even if the request is removed or its mask bit is set.
- R6: If no eligible request exists when the first acknowledge pulse arrives, the vector is `{base, 3'd7}` and no in-service bit is set.
- R7: `init_stb` clears the request latch and loads `init_base` as the vector base.
- R8: A level whose bit in the mask register is 1 never raises `int_out` and never wins arbitration. The mask register is loaded from `mask_data` when `mask_we` is high.
- R9: The first rising edge of `ack_in` drops `int_out` on that clock edge. The second rising edge sets `vec_valid` for exactly one cycle, with `vec_out` valid. After reset, `int_out` and `vec_valid` are low.
- R10: `int_out` stays low for the whole acknowledge sequence. It is re-evaluated on the clock after the second acknowledge, from the held latch contents.
- R11: A request rising on the synchronized inputs raises `int_out` on the fourth rising clock edge after the input changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 8 | Asynchronous request lines, bit 0 most urgent |
| mask_we | input | 1 | Mask register write enable |
| mask_data | input | 8 | New mask value, 1 = level disabled |
| eoi_stb | input | 1 | End-of-interrupt command |
| init_stb | input | 1 | Initialization: clear request latch, load base |
| init_base | input | 5 | Vector base loaded on `init_stb` |
| int_out | output | 1 | Interrupt request to the processor |
| ack_in | input | 1 | Acknowledge pulses from the processor |
| vec_out | output | 8 | Returned vector |
| vec_valid | output | 1 | One-cycle strobe marking `vec_out` |

## Verification
The hardest case is a request that is withdrawn, or masked, after `int_out` is already high but before the first acknowledge pulse. The bench waits until the interrupt is raised and then removes the line or writes its mask bit. It waits long enough for the synchronizer and latch to clear before it acknowledges, and it expects the level-7 vector.

Whether the spurious answer left in-service bit 7 clear cannot be seen directly at the ports. The bench therefore raises line 7 afterwards: if bit 7 were wrongly set, `int_out` would stay low. The freezing of the latch is observed in a similar way. A request arrives between the two pulses, and the bench checks that `int_out` stays low on the first clock after the second pulse and rises only on the clock after that.

// File: rtl/pic_pkg.sv
package pic_pkg;
    typedef enum logic {
        SEQ_IDLE  = 1'b0,
        SEQ_WAIT2 = 1'b1
    } seq_e;
endpackage

// File: rtl/pic_sync.sv
module pic_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] s1_q, s2_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= async_in;
            s2_q <= s1_q;
        end
    end

    assign sync_out = s2_q;
endmodule

// File: rtl/pic_lowest_set.sv
module pic_lowest_set #(
    parameter int N  = 8,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/pic_resolver.sv
module pic_resolver #(
    parameter int N  = 8,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    input  logic [N-1:0]  mask,
    input  logic [N-1:0]  isr,
    output logic          hit,
    output logic [IW-1:0] lvl
);
    logic [N-1:0] allowed;
    logic [N-1:0] cand;

    // a level may compete only when no in-service bit sits at or above its urgency
    for (genvar g = 0; g < N; g++) begin : g_allow
        assign allowed[g] = ~|isr[g:0];
    end

    assign cand = req & ~mask & allowed;

    pic_lowest_set #(.N(N)) u_pick (
        .vec   (cand),
        .found (hit),
        .idx   (lvl)
    );
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
    parameter int N_LVL = 8,
    parameter int VEC_W = 8,
    localparam int LW = $clog2(N_LVL),
    localparam int BW = VEC_W - LW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_LVL-1:0] irq_in,
    input  logic             mask_we,
    input  logic [N_LVL-1:0] mask_data,
    input  logic             eoi_stb,
    input  logic             init_stb,
    input  logic [BW-1:0]    init_base,
    output logic             int_out,
    input  logic             ack_in,
    output logic [VEC_W-1:0] vec_out,
    output logic             vec_valid
);
    import pic_pkg::*;

    typedef struct packed {
        logic [N_LVL-1:0] irr;
        logic [N_LVL-1:0] imr;
        logic [N_LVL-1:0] isr;
        logic [BW-1:0]    base;
        logic [LW-1:0]    sel;
        logic             intr;
        logic             ackq;
        seq_e             seq;
        logic [VEC_W-1:0] vec;
        logic             vld;
    } st_t;

    st_t st_d, st_q;

    logic [N_LVL-1:0] irq_sync;
    logic             hit;
    logic [LW-1:0]    win_lvl;
    logic             isr_any;
    logic [LW-1:0]    isr_top;
    logic             ack_rise;

    pic_sync #(.WIDTH(N_LVL)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (irq_in),
        .sync_out (irq_sync)
    );

    pic_resolver #(.N(N_LVL)) u_res (
        .req  (st_q.irr),
        .mask (st_q.imr),
        .isr  (st_q.isr),
        .hit  (hit),
        .lvl  (win_lvl)
    );

    pic_lowest_set #(.N(N_LVL)) u_eoi (
        .vec   (st_q.isr),
        .found (isr_any),
        .idx   (isr_top)
    );

    assign ack_rise = ack_in & ~st_q.ackq;

    always_comb begin
        st_d      = st_q;
        st_d.ackq = ack_in;
        st_d.vld  = 1'b0;

        if (mask_we) st_d.imr = mask_data;
        if (eoi_stb && isr_any) st_d.isr[isr_top] = 1'b0;

        case (st_q.seq)
            SEQ_IDLE: begin
                st_d.irr  = irq_sync;
                st_d.intr = st_q.intr | hit;
                if (ack_rise) begin
                    st_d.seq  = SEQ_WAIT2;
                    st_d.intr = 1'b0;
                    st_d.irr  = st_q.irr;
                    if (hit) begin
                        st_d.isr[win_lvl] = 1'b1;
                        st_d.irr[win_lvl] = 1'b0;
                        st_d.sel          = win_lvl;
                    end else begin
                        st_d.sel = '1;
                    end
                end
            end
            SEQ_WAIT2: begin
                st_d.intr = 1'b0;
                if (ack_rise) begin
                    st_d.seq = SEQ_IDLE;
                    st_d.vld = 1'b1;
                    st_d.vec = {st_q.base, st_q.sel};
                end
            end
            default: st_d.seq = SEQ_IDLE;
        endcase

        if (init_stb) begin
            st_d.irr  = '0;
            st_d.base = init_base;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{irr: '0, imr: '0, isr: '0, base: '0, sel: '0,
                      intr: 1'b0, ackq: 1'b0, seq: SEQ_IDLE, vec: '0, vld: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign int_out   = st_q.intr;
    assign vec_out   = st_q.vec;
    assign vec_valid = st_q.vld;

    // R9
    vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.vld |=> !st_q.vld);

    // R10
    no_int_wait2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.seq == SEQ_WAIT2) |-> !st_q.intr);

    // R5
    int_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.intr && !ack_rise) |=> st_q.intr);

    // R6
    spur_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rise && st_q.seq == SEQ_IDLE && !hit && !eoi_stb)
        |=> (st_q.isr == $past(st_q.isr)));

    // R4
    irr_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.seq == SEQ_WAIT2 && !init_stb) |=> $stable(st_q.irr));

    // R8
    win_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rise && st_q.seq == SEQ_IDLE && hit)
        |-> (!st_q.imr[win_lvl] && st_q.irr[win_lvl]));
endmodule

// File: tb/sim_prio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_prio_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq = '0;
    logic       mask_we = 1'b0;
    logic [7:0] mask_data = '0;
    logic       eoi = 1'b0;
    logic       init = 1'b0;
    logic [4:0] init_base = '0;
    logic       ack = 1'b0;
    logic       int_o;
    logic [7:0] vec;
    logic       vld;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    prio_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .irq_in(irq), .mask_we(mask_we),
        .mask_data(mask_data), .eoi_stb(eoi), .init_stb(init),
        .init_base(init_base), .int_out(int_o), .ack_in(ack),
        .vec_out(vec), .vec_valid(vld)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_irq(input logic [7:0] v);
        @(negedge clk); irq = v;
    endtask

    task automatic do_eoi();
        @(negedge clk); eoi = 1'b1;
        @(negedge clk); eoi = 1'b0;
    endtask

    task automatic put_mask(input logic [7:0] m);
        @(negedge clk); mask_we = 1'b1; mask_data = m;
        @(negedge clk); mask_we = 1'b0;
    endtask

    task automatic ack1();
        @(negedge clk); ack = 1'b1;
        @(negedge clk); ack = 1'b0;
    endtask

    task automatic ack2(output logic [7:0] v, output logic ok);
        @(negedge clk); ack = 1'b1;
        @(negedge clk); v = vec; ok = vld; ack = 1'b0;
    endtask

    task automatic ack_pair(input string tag, input logic [7:0] exp);
        logic [7:0] v;
        logic ok;
        ack1();
        ack2(v, ok);
        chk(tag, {7'd0, ok}, 8'd1);
        chk(tag, v, exp);
    endtask

    task automatic cleanup();
        set_irq(8'h00);
        put_mask(8'h00);
        for (int i = 0; i < 8; i++) do_eoi();
        wait_n(6);
    endtask

    task automatic t_reset();
        chk("R9 reset int", {7'd0, int_o}, 8'd0);
        chk("R9 reset vld", {7'd0, vld}, 8'd0);
        @(negedge clk); init = 1'b1; init_base = 5'h11;
        @(negedge clk); init = 1'b0;
    endtask

    task automatic t_latency_prio();
        logic [7:0] v;
        logic ok;
        set_irq(8'b0010_1000);
        wait_n(3);
        chk("R11 early", {7'd0, int_o}, 8'd0);
        wait_n(1);
        chk("R11 rise", {7'd0, int_o}, 8'd1);
        ack1();
        chk("R9 drop", {7'd0, int_o}, 8'd0);
        ack2(v, ok);
        chk("R9 vld", {7'd0, ok}, 8'd1);
        chk("R1 vec", v, 8'h8B);
        wait_n(1);
        chk("R9 one cycle", {7'd0, vld}, 8'd0);
    endtask

    task automatic t_isr_eoi();
        wait_n(6);
        chk("R2 blocked", {7'd0, int_o}, 8'd0);
        set_irq(8'b0010_1010);
        wait_n(5);
        chk("R2 higher", {7'd0, int_o}, 8'd1);
        ack_pair("R2 vec", 8'h89);
        set_irq(8'b0010_1000);
        wait_n(6);
        chk("R2 nested", {7'd0, int_o}, 8'd0);
        do_eoi();
        wait_n(3);
        chk("R3 still", {7'd0, int_o}, 8'd0);
        set_irq(8'b0010_1100);
        wait_n(5);
        chk("R3 lowest cleared", {7'd0, int_o}, 8'd1);
        ack_pair("R3 vec", 8'h8A);
        cleanup();
    endtask

    task automatic t_freeze();
        logic [7:0] v;
        logic ok;
        set_irq(8'b0001_0000);
        wait_n(5);
        ack1();
        set_irq(8'b0000_0001);
        wait_n(5);
        ack2(v, ok);
        chk("R4 vec", v, 8'h8C);
        wait_n(1);
        chk("R4 frozen", {7'd0, int_o}, 8'd0);
        wait_n(1);
        chk("R4 transparent", {7'd0, int_o}, 8'd1);
        ack_pair("R4 late", 8'h88);
        cleanup();
    endtask

    task automatic t_reeval();
        logic [7:0] v;
        logic ok;
        set_irq(8'b0100_1000);
        wait_n(5);
        ack1();
        do_eoi();
        ack2(v, ok);
        chk("R10 vec", v, 8'h8B);
        chk("R10 low at end", {7'd0, int_o}, 8'd0);
        wait_n(1);
        chk("R10 next clock", {7'd0, int_o}, 8'd1);
        cleanup();
    endtask

    task automatic t_spur_drop();
        set_irq(8'b0100_0000);
        wait_n(5);
        set_irq(8'h00);
        wait_n(5);
        chk("R5 held", {7'd0, int_o}, 8'd1);
        ack_pair("R6 spurious", 8'h8F);
        set_irq(8'b1000_0000);
        wait_n(5);
        chk("R6 no isr7", {7'd0, int_o}, 8'd1);
        ack_pair("R6 real7", 8'h8F);
        cleanup();
    endtask

    task automatic t_spur_mask();
        set_irq(8'b0010_0000);
        wait_n(5);
        put_mask(8'h20);
        wait_n(4);
        chk("R5 masked held", {7'd0, int_o}, 8'd1);
        ack_pair("R8 spurious", 8'h8F);
        wait_n(6);
        chk("R8 masked idle", {7'd0, int_o}, 8'd0);
        put_mask(8'h00);
        wait_n(2);
        chk("R8 unmask", {7'd0, int_o}, 8'd1);
        ack_pair("R8 vec", 8'h8D);
        cleanup();
    endtask

    task automatic t_init();
        logic [7:0] v;
        logic ok;
        set_irq(8'b0100_0100);
        wait_n(5);
        ack1();
        do_eoi();
        @(negedge clk); init = 1'b1; init_base = 5'h03; irq = 8'h00;
        @(negedge clk); init = 1'b0;
        ack2(v, ok);
        chk("R7 base", v, 8'h1A);
        wait_n(4);
        chk("R7 cleared", {7'd0, int_o}, 8'd0);
        cleanup();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);
        t_reset();
        t_latency_prio();
        t_isr_eoi();
        t_freeze();
        t_reeval();
        t_spur_drop();
        t_spur_mask();
        t_init();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule